// File: doc/BRIEF.md
# Linked Frame-Descriptor Fetch Engine

This block walks a chain of frame descriptors held in system memory and streams the pixel words of each frame into an internal output FIFO. A display pipeline drains the FIFO one word at a time. Each descriptor occupies four consecutive 32-bit words. It names the next descriptor, the frame buffer, a frame identifier and a command word. The command word carries the frame length in words and per-frame interrupt requests. Because each frame carries its own settings, a descriptor that points back to itself makes the same buffer scan out over and over with no software involvement.

The engine owns a simple burst read master. Descriptor fetches use one 4-beat burst. Frame data is read in fixed bursts of 4, 8 or 16 words, and the last burst of a frame is shortened to the words that remain. A data burst is only requested when the FIFO has room for a full configured burst. Status outputs show the frame identifier, buffer start address and palette flag of the frame being shown. Single-cycle start-of-frame and end-of-frame pulses and a sticky underflow flag complete the interface.

Top module: `frame_desc_fetcher`

## Requirements
- R1: A descriptor is fetched as one 4-beat burst at the descriptor address. Its words are taken in this order: next-descriptor address, buffer address, frame identifier, command word.
- R2: Command bits [11:0] give the frame length in 32-bit words. The words are read upward from the buffer address in steps of 4 bytes and appear on `pix_data` in that order.
- R3: `burst_sel` picks the data burst length: 0 gives 4, 1 gives 8, 2 gives 16, 3 gives 4. When fewer words remain, the last burst of a frame carries only those words. `rd_len` always lies in 1..16.
- R4: A data burst is requested only when the FIFO free space is at least the configured burst length. The FIFO never holds more than its depth.
- R5: `sof_irq` pulses for one cycle after a descriptor whose command bit 15 is set has been fetched. `eof_irq` pulses for one cycle after the last word of a frame whose command bit 16 is set. The two never pulse in the same cycle.
- R6: In the cycle of that frame's start-of-frame slot, `cur_frame_id` and `cur_src_addr` take the frame identifier and buffer start address. `cur_palette` takes command bit 12 in the same cycle. Bit 12 has no effect on the fetch.
- R7: After a frame, the engine fetches the descriptor named by the next field. A descriptor that names itself repeats its frame.
- R8: While idle and `run` is high, the engine loads `head_addr` and starts fetching. `run` is sampled at the end of each frame, and the engine goes idle if it is low. No request is made while idle.
- R9: `underflow` sets when `disp_pop` is high while `pix_valid` is low. It stays set until the next start from idle.
- R10: A frame of length 0 issues no data burst but still gives its start-of-frame and end-of-frame pulses.
- R11: After reset: no request, FIFO empty, no pulses, `underflow` clear, status outputs zero.
- R12: Once raised, a request holds `rd_addr` and `rd_len` unchanged until `rd_gnt` accepts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Traversal enable, sampled at frame ends |
| head_addr | input | ADDR_W | First descriptor byte address |
| burst_sel | input | 2 | Data burst length select |
| rd_req | output | 1 | Burst read request |
| rd_addr | output | ADDR_W | Burst start byte address |
| rd_len | output | 5 | Burst length in words |
| rd_gnt | input | 1 | Request accepted this cycle |
| rd_valid | input | 1 | Read data beat valid |
| rd_data | input | 32 | Read data beat |
| disp_pop | input | 1 | Display takes the head word |
| pix_valid | output | 1 | FIFO holds at least one word |
| pix_data | output | 32 | FIFO head word |
| underflow | output | 1 | Sticky pop-while-empty flag |
| sof_irq | output | 1 | Start-of-frame pulse |
| eof_irq | output | 1 | End-of-frame pulse |
| cur_frame_id | output | 32 | Identifier of current frame |
| cur_src_addr | output | ADDR_W | Buffer start of current frame |
| cur_palette | output | 1 | Palette flag of current frame |

## Verification
A corrupted beat counter or word-select inside the descriptor fetch swaps descriptor fields. The scoreboard catches this at the first pixel word, or the status check catches it at the first start-of-frame. A wrong remaining-word count either shortens the frame, which leaves words in the expected queue, or runs past it. It also changes the logged burst lengths within one frame. A broken free-space test lets the FIFO fill past its depth and loses words. The stalled-display test exposes this within the third burst, because a request appears while `pix_valid` is high and nothing is popped.

// File: rtl/fdf_pkg.sv
package fdf_pkg;
  localparam int WORD_W      = 32;
  localparam int BLEN_W      = 5;
  localparam int MAX_BURST   = 16;
  localparam int DESC_WORDS  = 4;
  localparam int CMD_PAL_BIT = 12;
  localparam int CMD_SOF_BIT = 15;
  localparam int CMD_EOF_BIT = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_DREQ, ST_DDATA, ST_FSTART, ST_FREQ, ST_FDATA, ST_FEND
  } fetch_st_e;

  // burst select decode; the reserved code falls back to the shortest burst
  function automatic logic [BLEN_W-1:0] burst_words(input logic [1:0] sel);
    case (sel)
      2'b01:   return 5'd8;
      2'b10:   return 5'd16;
      default: return 5'd4;
    endcase
  endfunction
endpackage

// File: rtl/fdf_rst_sync.sv
module fdf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_n_sync <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_n_sync <= meta_q;
    end
  end
endmodule

// File: rtl/fdf_fifo.sv
module fdf_fifo #(
  parameter int DEPTH = 32,
  parameter int W     = 32,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] level
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic             do_push, do_pop;

  assign do_push = push && (level != CNT_W'(DEPTH));
  assign do_pop  = pop && (level != '0);
  assign head    = mem_q[rd_ptr_q];

  always_ff @(posedge clk) begin
    if (do_push) mem_q[wr_ptr_q] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      level    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= wr_ptr_q + 1'b1;
      if (do_pop)  rd_ptr_q <= rd_ptr_q + 1'b1;
      if (do_push != do_pop) level <= do_push ? level + 1'b1 : level - 1'b1;
    end
  end
endmodule

// File: rtl/fdf_engine.sv
module fdf_engine
  import fdf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [1:0]        burst_sel,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [BLEN_W-1:0] rd_len,
  input  logic              rd_gnt,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  fifo_level,
  output logic              push,
  output logic              start_pulse,
  output logic              sof_irq,
  output logic              eof_irq,
  output logic [WORD_W-1:0] cur_frame_id,
  output logic [ADDR_W-1:0] cur_src_addr,
  output logic              cur_palette
);
  fetch_st_e         state_q, state_d;
  logic [ADDR_W-1:0] desc_ptr_q, nxt_ptr_q, buf_ptr_q;
  logic [WORD_W-1:0] fid_q;
  logic [LEN_W-1:0]  cmd_len_q, rem_q;
  logic              cmd_sof_q, cmd_eof_q, cmd_pal_q;
  logic [BLEN_W-1:0] beat_q, len_q, burst_w, issue_len;
  logic [CNT_W-1:0]  free_words;
  logic              space_ok, accept, beat_in, desc_in, desc_last, data_last;

  assign burst_w    = burst_words(burst_sel);
  assign issue_len  = (rem_q < LEN_W'(burst_w)) ? BLEN_W'(rem_q) : burst_w;
  assign free_words = CNT_W'(FIFO_DEPTH) - fifo_level;
  assign space_ok   = free_words >= CNT_W'(burst_w);

  assign rd_req  = (state_q == ST_DREQ) || ((state_q == ST_FREQ) && space_ok);
  assign rd_addr = (state_q == ST_DREQ) ? desc_ptr_q : buf_ptr_q;
  assign rd_len  = (state_q == ST_DREQ) ? BLEN_W'(DESC_WORDS) : issue_len;
  assign accept  = rd_req && rd_gnt;

  assign beat_in     = rd_valid && ((state_q == ST_DDATA) || (state_q == ST_FDATA));
  assign desc_in     = beat_in && (state_q == ST_DDATA);
  assign push        = beat_in && (state_q == ST_FDATA);
  assign desc_last   = beat_q == BLEN_W'(DESC_WORDS - 1);
  assign data_last   = beat_q == (len_q - 1'b1);
  assign start_pulse = (state_q == ST_IDLE) && run;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (run) state_d = ST_DREQ;
      ST_DREQ:   if (accept) state_d = ST_DDATA;
      ST_DDATA:  if (beat_in && desc_last) state_d = ST_FSTART;
      ST_FSTART: state_d = (cmd_len_q == '0) ? ST_FEND : ST_FREQ;
      ST_FREQ:   if (accept) state_d = ST_FDATA;
      ST_FDATA:  if (beat_in && data_last)
                   state_d = (rem_q == LEN_W'(1)) ? ST_FEND : ST_FREQ;
      ST_FEND:   state_d = run ? ST_DREQ : ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // descriptor pointer and burst bookkeeping
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      desc_ptr_q <= '0;
      beat_q     <= '0;
      len_q      <= '0;
    end else begin
      if (start_pulse)            desc_ptr_q <= head_addr;
      else if (state_q == ST_FEND) desc_ptr_q <= nxt_ptr_q;
      if (accept) begin
        beat_q <= '0;
        len_q  <= rd_len;
      end else if (beat_in) begin
        beat_q <= beat_q + 1'b1;
      end
    end
  end

  // descriptor capture, word order: next, buffer, id, command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nxt_ptr_q <= '0;
      buf_ptr_q <= '0;
      fid_q     <= '0;
      cmd_len_q <= '0;
      cmd_sof_q <= 1'b0;
      cmd_eof_q <= 1'b0;
      cmd_pal_q <= 1'b0;
      rem_q     <= '0;
    end else begin
      if (desc_in && (beat_q[1:0] == 2'd0)) nxt_ptr_q <= rd_data[ADDR_W-1:0];
      if (desc_in && (beat_q[1:0] == 2'd1)) buf_ptr_q <= rd_data[ADDR_W-1:0];
      else if (push)                        buf_ptr_q <= buf_ptr_q + ADDR_W'(4);
      if (desc_in && (beat_q[1:0] == 2'd2)) fid_q <= rd_data;
      if (desc_in && (beat_q[1:0] == 2'd3)) begin
        cmd_len_q <= rd_data[LEN_W-1:0];
        cmd_sof_q <= rd_data[CMD_SOF_BIT];
        cmd_eof_q <= rd_data[CMD_EOF_BIT];
        cmd_pal_q <= rd_data[CMD_PAL_BIT];
      end
      if (state_q == ST_FSTART) rem_q <= cmd_len_q;
      else if (push)            rem_q <= rem_q - 1'b1;
    end
  end

  // status and interrupt pulses
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_frame_id <= '0;
      cur_src_addr <= '0;
      cur_palette  <= 1'b0;
      sof_irq      <= 1'b0;
      eof_irq      <= 1'b0;
    end else begin
      if (state_q == ST_FSTART) begin
        cur_frame_id <= fid_q;
        cur_src_addr <= buf_ptr_q;
        cur_palette  <= cmd_pal_q;
      end
      sof_irq <= (state_q == ST_FSTART) && cmd_sof_q;
      eof_irq <= (state_q == ST_FEND) && cmd_eof_q;
    end
  end
endmodule

// File: rtl/frame_desc_fetcher.sv
module frame_desc_fetcher
  import fdf_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 12,
  parameter int FIFO_DEPTH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [ADDR_W-1:0] head_addr,
  input  logic [1:0]        burst_sel,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [4:0]        rd_len,
  input  logic              rd_gnt,
  input  logic              rd_valid,
  input  logic [31:0]       rd_data,
  input  logic              disp_pop,
  output logic              pix_valid,
  output logic [31:0]       pix_data,
  output logic              underflow,
  output logic              sof_irq,
  output logic              eof_irq,
  output logic [31:0]       cur_frame_id,
  output logic [ADDR_W-1:0] cur_src_addr,
  output logic              cur_palette
);
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic             rst_n_s, push, start_pulse;
  logic [CNT_W-1:0] fifo_level;

  fdf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_n_s));

  fdf_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)
  ) u_eng (
    .clk(clk), .rst_n(rst_n_s), .run(run), .head_addr(head_addr),
    .burst_sel(burst_sel), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
    .fifo_level(fifo_level), .push(push), .start_pulse(start_pulse),
    .sof_irq(sof_irq), .eof_irq(eof_irq), .cur_frame_id(cur_frame_id),
    .cur_src_addr(cur_src_addr), .cur_palette(cur_palette)
  );

  fdf_fifo #(.DEPTH(FIFO_DEPTH), .W(WORD_W), .CNT_W(CNT_W)) u_fifo (
    .clk(clk), .rst_n(rst_n_s), .push(push), .push_data(rd_data),
    .pop(disp_pop), .head(pix_data), .level(fifo_level)
  );

  assign pix_valid = fifo_level != '0;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)                    underflow <= 1'b0;
    else if (start_pulse)            underflow <= 1'b0;
    else if (disp_pop && !pix_valid) underflow <= 1'b1;
  end
endmodule

// File: rtl/fdf_checker.sv
module fdf_checker #(
  parameter int FIFO_DEPTH = 32,
  parameter int CNT_W      = 6,
  parameter int ADDR_W     = 32,
  parameter int BLEN_W     = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_req,
  input logic              rd_gnt,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [BLEN_W-1:0] rd_len,
  input logic              sof_irq,
  input logic              eof_irq,
  input logic              underflow,
  input logic              start_pulse,
  input logic [CNT_W-1:0]  fifo_level
);
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (rd_len != '0) && (rd_len <= BLEN_W'(16))); // R3

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_gnt |=> rd_req && $stable(rd_addr) && $stable(rd_len)); // R12

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_level <= CNT_W'(FIFO_DEPTH)); // R4

  AST_PULSES_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !(sof_irq && eof_irq)); // R5

  AST_UNDERFLOW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    underflow && !start_pulse |=> underflow); // R9
endmodule

bind frame_desc_fetcher fdf_checker #(
  .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .BLEN_W(5)
) u_fdf_chk (
  .clk(clk), .rst_n(rst_n_s), .rd_req(rd_req), .rd_gnt(rd_gnt),
  .rd_addr(rd_addr), .rd_len(rd_len), .sof_irq(sof_irq), .eof_irq(eof_irq),
  .underflow(underflow), .start_pulse(start_pulse), .fifo_level(fifo_level)
);

// File: tb/tb_frame_desc_fetcher.sv
`timescale 1ns/1ps
module tb_frame_desc_fetcher;
  localparam logic [31:0] SOF = 32'h0000_8000;
  localparam logic [31:0] EOF = 32'h0001_0000;
  localparam logic [31:0] PAL = 32'h0000_1000;

  logic        clk = 1'b0;
  logic        rst_n, run, rd_req, rd_gnt, rd_valid, disp_pop;
  logic        pix_valid, underflow, sof_irq, eof_irq, cur_palette;
  logic [31:0] head_addr, rd_addr, rd_data, pix_data, cur_frame_id, cur_src_addr;
  logic [1:0]  burst_sel;
  logic [4:0]  rd_len;

  always #2.5 clk = ~clk;

  frame_desc_fetcher dut (
    .clk(clk), .rst_n(rst_n), .run(run), .head_addr(head_addr),
    .burst_sel(burst_sel), .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len),
    .rd_gnt(rd_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
    .disp_pop(disp_pop), .pix_valid(pix_valid), .pix_data(pix_data),
    .underflow(underflow), .sof_irq(sof_irq), .eof_irq(eof_irq),
    .cur_frame_id(cur_frame_id), .cur_src_addr(cur_src_addr),
    .cur_palette(cur_palette)
  );

  logic [31:0] mem [1024];
  logic [31:0] exp_q [$];
  logic [31:0] desc_addrs [$];
  logic [31:0] sof_ids [$];
  int          data_lens [$];
  int          errors = 0, checks = 0, sof_cnt = 0, eof_cnt = 0, gnt_wait = 0;
  bit          pop_en = 1'b0, force_pop = 1'b0, done = 1'b0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic put_desc(input logic [31:0] at, nxt, bufa, id, cmd);
    mem[int'(at >> 2)]     = nxt;
    mem[int'(at >> 2) + 1] = bufa;
    mem[int'(at >> 2) + 2] = id;
    mem[int'(at >> 2) + 3] = cmd;
  endtask

  // driver side of the scoreboard: fills the buffer and queues expected words
  task automatic put_frame(input logic [31:0] bufa, input int n, input logic [31:0] seed, input int reps);
    for (int i = 0; i < n; i++) mem[int'(bufa >> 2) + i] = seed + 32'(i * 32'h0101_0001);
    for (int r = 0; r < reps; r++)
      for (int i = 0; i < n; i++) exp_q.push_back(mem[int'(bufa >> 2) + i]);
  endtask

  task automatic check_lens(input int base, input int n, input int e[8], input string rq);
    chk(data_lens.size() == base + n, rq, 32'(data_lens.size() - base), 32'(n));
    if (data_lens.size() == base + n)
      for (int i = 0; i < n; i++)
        chk(data_lens[base + i] == e[i], rq, 32'(data_lens[base + i]), 32'(e[i]));
  endtask

  task automatic wait_eofs(input int target, input string rq);
    int t = 0;
    while (eof_cnt < target && t < 20000) begin
      @(negedge clk);
      t++;
    end
    chk(eof_cnt >= target, rq, 32'(eof_cnt), 32'(target));
  endtask

  task automatic pulse_run();
    run = 1'b1;
    repeat (2) @(negedge clk);
    run = 1'b0;
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // memory model: accepts at the edge after a negedge with req and gnt
  initial begin
    rd_gnt = 1'b1;
    rd_valid = 1'b0;
    rd_data = '0;
    @(negedge clk);
    forever begin
      if (rst_n === 1'b1 && rd_req && rd_gnt) begin
        logic [31:0] a;
        int n;
        a = rd_addr;
        n = int'(rd_len);
        if (a < 32'h100) desc_addrs.push_back(a);
        else data_lens.push_back(n);
        @(posedge clk);
        #1 rd_gnt = 1'b0;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
          rd_valid = 1'b1;
          rd_data = mem[int'(a >> 2) + i];
          @(negedge clk);
        end
        rd_valid = 1'b0;
        repeat (gnt_wait) @(negedge clk);
        rd_gnt = 1'b1;
      end else begin
        @(negedge clk);
      end
    end
  end

  // monitor: pops the FIFO and compares against the expected queue
  initial begin
    disp_pop = 1'b0;
    forever begin
      @(negedge clk);
      if (sof_irq) begin
        sof_cnt++;
        sof_ids.push_back(cur_frame_id);
      end
      if (eof_irq) eof_cnt++;
      if (pop_en && pix_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R2 unexpected word", pix_data, 32'h0);
        else begin
          logic [31:0] e;
          e = exp_q.pop_front();
          chk(pix_data == e, "R2 word order", pix_data, e);
        end
        disp_pop = 1'b1;
      end else begin
        disp_pop = force_pop;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    int lb, db, sb, eb;
    rst_n = 1'b0;
    run = 1'b0;
    head_addr = '0;
    burst_sel = 2'd0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(rd_req == 1'b0, "R11 rd_req", 32'(rd_req), 0);
    chk(pix_valid == 1'b0, "R11 pix_valid", 32'(pix_valid), 0);
    chk(!sof_irq && !eof_irq, "R11 pulses", {sof_irq, eof_irq}, 0);
    chk(underflow == 1'b0, "R11 underflow", 32'(underflow), 0);
    chk(cur_frame_id == 0 && cur_src_addr == 0, "R11 status", cur_frame_id, 0);

    // two-frame chain, 4-word bursts, grant stalls: R1 R2 R3 R5 R6 R7 R8
    put_desc(32'h000, 32'h010, 32'h400, 32'h11, 32'd10 | SOF | EOF);
    put_frame(32'h400, 10, 32'hA000_0000, 1);
    put_desc(32'h010, 32'h020, 32'h600, 32'h22, 32'd5 | EOF | PAL);
    put_frame(32'h600, 5, 32'hB000_0000, 1);
    head_addr = 32'h000;
    pop_en = 1'b1;
    gnt_wait = 2;
    run = 1'b1;
    wait_eofs(1, "R7 first frame end");
    run = 1'b0;
    wait_eofs(2, "R8 current frame finishes");
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all words delivered", 32'(exp_q.size()), 0);
    check_lens(0, 5, '{4, 4, 2, 4, 1, 0, 0, 0}, "R3 shortened last burst");
    chk(desc_addrs.size() == 2, "R1 descriptor bursts", 32'(desc_addrs.size()), 2);
    if (desc_addrs.size() == 2) begin
      chk(desc_addrs[0] == 32'h000, "R1 head descriptor", desc_addrs[0], 32'h000);
      chk(desc_addrs[1] == 32'h010, "R7 next pointer", desc_addrs[1], 32'h010);
    end
    chk(sof_cnt == 1 && eof_cnt == 2, "R5 pulse counts", 32'(sof_cnt * 16 + eof_cnt), 32'h12);
    if (sof_ids.size() > 0) chk(sof_ids[0] == 32'h11, "R6 id at sof", sof_ids[0], 32'h11);
    chk(cur_frame_id == 32'h22, "R6 frame id", cur_frame_id, 32'h22);
    chk(cur_src_addr == 32'h600, "R6 source address", cur_src_addr, 32'h600);
    chk(cur_palette == 1'b1, "R6 palette flag", 32'(cur_palette), 1);
    chk(rd_req == 1'b0, "R8 idle no request", 32'(rd_req), 0);

    // stalled display, 16-word bursts: R4
    lb = data_lens.size();
    eb = eof_cnt;
    pop_en = 1'b0;
    burst_sel = 2'd2;
    put_desc(32'h040, 32'h040, 32'h800, 32'h55, 32'd40 | EOF);
    put_frame(32'h800, 40, 32'hC000_0000, 1);
    head_addr = 32'h040;
    run = 1'b1;
    repeat (300) @(negedge clk);
    chk(data_lens.size() == lb + 2, "R4 bursts before full", 32'(data_lens.size() - lb), 2);
    chk(rd_req == 1'b0, "R4 no request when full", 32'(rd_req), 0);
    chk(pix_valid == 1'b1, "R4 words held", 32'(pix_valid), 1);
    run = 1'b0;
    pop_en = 1'b1;
    wait_eofs(eb + 1, "R4 frame completes");
    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R4 no word lost", 32'(exp_q.size()), 0);
    check_lens(lb, 3, '{16, 16, 8, 0, 0, 0, 0, 0}, "R4 burst lengths");

    // self-pointing descriptor, 8-word bursts: R7
    lb = data_lens.size();
    db = desc_addrs.size();
    sb = sof_cnt;
    eb = eof_cnt;
    burst_sel = 2'd1;
    gnt_wait = 0;
    put_desc(32'h080, 32'h080, 32'hA00, 32'h33, 32'd12 | SOF | EOF);
    put_frame(32'hA00, 12, 32'hD000_0000, 3);
    head_addr = 32'h080;
    run = 1'b1;
    wait_eofs(eb + 2, "R7 repeat");
    run = 1'b0;
    wait_eofs(eb + 3, "R7 third pass");
    repeat (30) @(negedge clk);
    chk(exp_q.size() == 0, "R7 repeated frame words", 32'(exp_q.size()), 0);
    chk(desc_addrs.size() == db + 3, "R7 descriptor refetch", 32'(desc_addrs.size() - db), 3);
    if (desc_addrs.size() == db + 3)
      chk(desc_addrs[db + 2] == 32'h080, "R7 self address", desc_addrs[db + 2], 32'h080);
    chk(sof_cnt == sb + 3, "R5 sof per pass", 32'(sof_cnt - sb), 3);
    check_lens(lb, 6, '{8, 4, 8, 4, 8, 4, 0, 0}, "R3 eight-word bursts");

    // zero-length frame: R10
    lb = data_lens.size();
    sb = sof_cnt;
    eb = eof_cnt;
    put_desc(32'h0C0, 32'h0C0, 32'hC00, 32'h44, SOF | EOF);
    head_addr = 32'h0C0;
    pulse_run();
    wait_eofs(eb + 1, "R10 end pulse");
    repeat (10) @(negedge clk);
    chk(sof_cnt == sb + 1, "R10 start pulse", 32'(sof_cnt - sb), 1);
    chk(eof_cnt == eb + 1, "R10 single frame", 32'(eof_cnt - eb), 1);
    chk(data_lens.size() == lb, "R10 no data burst", 32'(data_lens.size() - lb), 0);
    chk(cur_frame_id == 32'h44, "R10 status", cur_frame_id, 32'h44);

    // underflow set, held, cleared by a start: R9
    force_pop = 1'b1;
    repeat (2) @(negedge clk);
    force_pop = 1'b0;
    repeat (2) @(negedge clk);
    chk(underflow == 1'b1, "R9 underflow set", 32'(underflow), 1);
    repeat (5) @(negedge clk);
    chk(underflow == 1'b1, "R9 underflow sticky", 32'(underflow), 1);
    eb = eof_cnt;
    pulse_run();
    @(negedge clk);
    chk(underflow == 1'b0, "R9 cleared by start", 32'(underflow), 0);
    wait_eofs(eb + 1, "R9 run completes");

    // reserved burst select behaves as four words: R3
    lb = data_lens.size();
    eb = eof_cnt;
    burst_sel = 2'd3;
    put_desc(32'h0E0, 32'h0E0, 32'hE00, 32'h66, 32'd6 | EOF);
    put_frame(32'hE00, 6, 32'hE000_0000, 1);
    head_addr = 32'h0E0;
    pulse_run();
    wait_eofs(eb + 1, "R3 reserved select frame");
    repeat (20) @(negedge clk);
    check_lens(lb, 2, '{4, 2, 0, 0, 0, 0, 0, 0}, "R3 reserved select");
    chk(exp_q.size() == 0, "R2 reserved select words", 32'(exp_q.size()), 0);

    done = 1'b1;
    report();
  end
endmodule